// File: doc/BRIEF.md
# Key-Return Interrupt and Wake Controller

This block watches a group of active-low key inputs and turns a falling edge on the group into one of three outcomes: a sticky interrupt request flag, a single-cycle wake pulse that releases STOP mode, or a single-cycle system reset request. The keys are synchronised, then combined with a logical AND. The group therefore produces an edge only when it goes from "no key pressed" to "at least one key pressed". While a key is held low, a press on any other key is masked.

A two-bit source-select register, written through a simple write port, decides whether the key group feeds the interrupt flag. The operating mode input and a synchronised reset-enable pin decide the outcome. In normal or HALT mode an edge raises the flag. In STOP mode with reset-enable high, an edge requests a system reset and wakes the core. In STOP mode with reset-enable low, an edge raises the flag and wakes the core only when interrupts are enabled. The flag stays set until a clear strobe arrives.

Top module: `keyret_wake_ctrl`

## Requirements
- R1: The source-select register clears to 00 on reset. With code 00, key edges never set the request flag.
- R2: With source code 01 and operating mode normal (00) or HALT (01), a falling edge of the AND of all synchronised keys sets the request flag. The state of the reset-enable pin makes no difference.
- R3: Source codes 10 and 11 never set the flag. Writing either code leaves the current flag value unchanged.
- R4: While any key is held low, a falling edge on another key does not set the flag.
- R5: Writing code 01 while a key is already held low sets the flag, because the request source itself falls.
- R6: Once set, the flag holds until a one-cycle clear strobe clears it.
- R7: When a set and the clear strobe land in the same cycle, the flag ends up set.
- R8: In STOP mode (10) with reset-enable high, a key-group falling edge produces exactly one single-cycle reset request pulse and one wake pulse, and leaves the flag alone. This holds whatever the interrupt enable and the source code.
- R9: In STOP mode with reset-enable low and source code 01, a key edge sets the flag. It produces a wake pulse only when the interrupt enable is high, and never a reset request.
- R10: Outside STOP mode, the reset request and the wake pulse stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_ni | input | N_KEYS | Active-low key inputs, asynchronous |
| rst_en_i | input | 1 | Reset-enable pin for STOP mode, asynchronous |
| op_mode_i | input | 2 | Operating mode: 00 normal, 01 HALT, 10 STOP, 11 behaves as normal |
| int_en_i | input | 1 | Interrupt enable; gates the wake in STOP when reset-enable is low |
| mode_we_i | input | 1 | Source-select register write strobe |
| mode_wdata_i | input | 2 | Source-select write data: 00 none, 01 keys, 10/11 prohibited |
| flag_clr_i | input | 1 | One-cycle clear strobe for the request flag |
| irq_flag_o | output | 1 | Sticky interrupt request flag |
| wake_o | output | 1 | One-cycle STOP release pulse |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The key group is driven with single key presses on different keys, with a press on a second key while a first is held, and with releases that produce only rising edges. These patterns separate AND-based masking from per-key edge detection. Each press is repeated under every source code and every operating mode. A source write while a key is held exposes the write side effect. A clear strobe placed in the exact cycle the flag sets shows whether set or clear has priority. In STOP mode, runs with the interrupt enable high and low, and with reset-enable high and low, separate the wake-only, flag-only and reset outcomes.

// File: rtl/keyret_pkg.sv
package keyret_pkg;
  typedef enum logic [1:0] {
    OP_NORMAL = 2'b00,
    OP_HALT   = 2'b01,
    OP_STOP   = 2'b10,
    OP_RSVD   = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_KEYS  = 2'b01,
    SRC_BAD_A = 2'b10,
    SRC_BAD_B = 2'b11
  } src_mode_e;

  localparam int unsigned SRC_W = 2;
endpackage

// File: rtl/keyret_sync.sv
module keyret_sync #(
  parameter int unsigned        WIDTH   = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stage[s-1].q;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/keyret_mode_reg.sv
module keyret_mode_reg
  import keyret_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] mode_q_o,
  output logic             keys_sel_o
);
  src_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= SRC_NONE;
    else if (we_i) mode_q <= src_mode_e'(wdata_i);
  end

  assign mode_q_o   = mode_q;
  assign keys_sel_o = (mode_q == SRC_KEYS);
endmodule

// File: rtl/keyret_edge.sv
module keyret_edge #(
  parameter int unsigned N_KEYS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_KEYS-1:0] key_sync_i,
  input  logic              keys_sel_i,
  output logic              grp_fall_o,
  output logic              src_fall_o
);
  logic grp_high, src_lvl;
  logic grp_prev_q, src_prev_q;

  // group is high only while no key is pressed
  assign grp_high = &key_sync_i;
  // unselected source idles high so it never falls
  assign src_lvl  = keys_sel_i ? grp_high : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_prev_q <= 1'b1;
      src_prev_q <= 1'b1;
    end else begin
      grp_prev_q <= grp_high;
      src_prev_q <= src_lvl;
    end
  end

  assign grp_fall_o = grp_prev_q & ~grp_high;
  assign src_fall_o = src_prev_q & ~src_lvl;
endmodule

// File: rtl/keyret_req_ctrl.sv
module keyret_req_ctrl
  import keyret_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       grp_fall_i,
  input  logic       src_fall_i,
  input  logic [1:0] op_mode_i,
  input  logic       rst_en_i,
  input  logic       int_en_i,
  input  logic       flag_clr_i,
  output logic       irq_flag_o,
  output logic       wake_o,
  output logic       sys_rst_req_o
);
  op_mode_e op_mode;
  logic in_stop, rst_path, flag_set, stop_wake;
  logic flag_q, wake_q, rst_q;

  assign op_mode   = op_mode_e'(op_mode_i);
  assign in_stop   = (op_mode == OP_STOP);
  assign rst_path  = in_stop & rst_en_i & grp_fall_i;
  assign flag_set  = src_fall_i & ~(in_stop & rst_en_i);
  assign stop_wake = in_stop & ~rst_en_i & src_fall_i & int_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      wake_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      // set has priority over clear
      if (flag_set)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      wake_q <= rst_path | stop_wake;
      rst_q  <= rst_path;
    end
  end

  assign irq_flag_o    = flag_q;
  assign wake_o        = wake_q;
  assign sys_rst_req_o = rst_q;
endmodule

// File: rtl/keyret_wake_ctrl.sv
module keyret_wake_ctrl
  import keyret_pkg::*;
#(
  parameter int unsigned N_KEYS      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_KEYS-1:0] key_ni,
  input  logic              rst_en_i,
  input  logic [1:0]        op_mode_i,
  input  logic              int_en_i,
  input  logic              mode_we_i,
  input  logic [1:0]        mode_wdata_i,
  input  logic              flag_clr_i,
  output logic              irq_flag_o,
  output logic              wake_o,
  output logic              sys_rst_req_o
);
  localparam logic [N_KEYS-1:0] KEY_IDLE = {N_KEYS{1'b1}};

  logic [N_KEYS-1:0] key_sync;
  logic              rst_en_sync;
  logic [SRC_W-1:0]  mode_q;
  logic              keys_sel, grp_fall, src_fall;

  keyret_sync #(.WIDTH(N_KEYS), .STAGES(SYNC_STAGES), .RST_VAL(KEY_IDLE)) u_key_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (key_ni), .q_o (key_sync)
  );

  keyret_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ren_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (rst_en_i), .q_o (rst_en_sync)
  );

  keyret_mode_reg u_mode (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (mode_we_i), .wdata_i (mode_wdata_i),
    .mode_q_o (mode_q), .keys_sel_o (keys_sel)
  );

  keyret_edge #(.N_KEYS(N_KEYS)) u_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .key_sync_i (key_sync), .keys_sel_i (keys_sel),
    .grp_fall_o (grp_fall), .src_fall_o (src_fall)
  );

  keyret_req_ctrl u_req (
    .clk_i (clk_i), .rst_ni (rst_ni), .grp_fall_i (grp_fall), .src_fall_i (src_fall),
    .op_mode_i (op_mode_i), .rst_en_i (rst_en_sync), .int_en_i (int_en_i),
    .flag_clr_i (flag_clr_i), .irq_flag_o (irq_flag_o), .wake_o (wake_o),
    .sys_rst_req_o (sys_rst_req_o)
  );
endmodule

// File: rtl/keyret_wake_ctrl_chk.sv
module keyret_wake_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] op_mode_i,
  input logic       flag_clr_i,
  input logic [1:0] mode_q,
  input logic       irq_flag_o,
  input logic       wake_o,
  input logic       sys_rst_req_o
);
  assert_rst_only_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> ($past(op_mode_i) == 2'b10));

  assert_wake_only_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(op_mode_i) == 2'b10));

  assert_rst_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o);

  assert_rst_no_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> !$rose(irq_flag_o));

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !flag_clr_i) |=> irq_flag_o);

  // flag may only rise from the key source (covers R1 and R3)
  assert_flag_src_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flag_o) |-> ($past(mode_q) == 2'b01));
endmodule

bind keyret_wake_ctrl keyret_wake_ctrl_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .op_mode_i (op_mode_i), .flag_clr_i (flag_clr_i),
  .mode_q (mode_q), .irq_flag_o (irq_flag_o), .wake_o (wake_o),
  .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/keyret_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module keyret_wake_ctrl_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] key_n = '1;
  logic         rst_en = 1'b0;
  logic [1:0]   op_mode = 2'b00;
  logic         int_en = 1'b0;
  logic         mode_we = 1'b0;
  logic [1:0]   mode_wdata = 2'b00;
  logic         flag_clr = 1'b0;
  logic         irq_flag, wake, sys_rst;

  int checks = 0;
  int fails = 0;
  int wake_cnt = 0;
  int rst_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyret_wake_ctrl #(.N_KEYS(N)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .key_ni (key_n), .rst_en_i (rst_en),
    .op_mode_i (op_mode), .int_en_i (int_en), .mode_we_i (mode_we),
    .mode_wdata_i (mode_wdata), .flag_clr_i (flag_clr), .irq_flag_o (irq_flag),
    .wake_o (wake), .sys_rst_req_o (sys_rst)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wake)    wake_cnt++;
      if (sys_rst) rst_cnt++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_keys(input logic [N-1:0] v);
    @(negedge clk);
    key_n = v;
    idle(6);
  endtask

  task automatic write_mode(input logic [1:0] v);
    @(negedge clk);
    mode_we = 1'b1;
    mode_wdata = v;
    @(negedge clk);
    mode_we = 1'b0;
    idle(4);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    idle(1);
  endtask

  task automatic zero_counts();
    wake_cnt = 0;
    rst_cnt = 0;
  endtask

  task automatic t_reset();
    check("R1", "flag after reset", irq_flag, 0);
    check("R1", "wake after reset", wake, 0);
    check("R1", "rst req after reset", sys_rst, 0);
    op_mode = 2'b00;
    set_keys(4'b1110);
    check("R1", "flag with source 00", irq_flag, 0);
    set_keys(4'b1111);
  endtask

  task automatic t_basic();
    write_mode(2'b01);
    op_mode = 2'b00;
    rst_en = 1'b1;
    idle(3);
    zero_counts();
    set_keys(4'b1110);
    check("R2", "flag normal mode", irq_flag, 1);
    check("R10", "rst req normal", rst_cnt, 0);
    check("R10", "wake normal", wake_cnt, 0);
    set_keys(4'b1111);
    idle(5);
    check("R6", "flag held", irq_flag, 1);
    clear_flag();
    check("R6", "flag cleared", irq_flag, 0);
    op_mode = 2'b01;
    rst_en = 1'b0;
    zero_counts();
    set_keys(4'b0111);
    check("R2", "flag HALT mode", irq_flag, 1);
    check("R10", "wake HALT", wake_cnt, 0);
    set_keys(4'b1111);
    clear_flag();
    op_mode = 2'b00;
  endtask

  task automatic t_mask();
    set_keys(4'b1101);
    check("R4", "first key sets", irq_flag, 1);
    clear_flag();
    set_keys(4'b1001);
    check("R4", "masked second key", irq_flag, 0);
    set_keys(4'b1011);
    set_keys(4'b1111);
    check("R4", "releases only", irq_flag, 0);
  endtask

  task automatic t_prohib();
    write_mode(2'b10);
    set_keys(4'b1110);
    check("R3", "flag code 10", irq_flag, 0);
    set_keys(4'b1111);
    write_mode(2'b11);
    set_keys(4'b1011);
    check("R3", "flag code 11", irq_flag, 0);
    set_keys(4'b1111);
    write_mode(2'b01);
    set_keys(4'b1110);
    set_keys(4'b1111);
    write_mode(2'b10);
    check("R3", "flag kept across prohibited write", irq_flag, 1);
    clear_flag();
    write_mode(2'b11);
    check("R3", "clear flag kept across prohibited write", irq_flag, 0);
  endtask

  task automatic t_side();
    write_mode(2'b00);
    set_keys(4'b1110);
    check("R5", "no flag before write", irq_flag, 0);
    write_mode(2'b01);
    check("R5", "flag on write with key held", irq_flag, 1);
    set_keys(4'b1111);
    clear_flag();
  endtask

  task automatic t_setwins();
    write_mode(2'b01);
    set_keys(4'b1110);
    set_keys(4'b1111);
    check("R7", "flag pre-set", irq_flag, 1);
    @(negedge clk);
    key_n = 4'b1101;
    @(negedge clk);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    idle(2);
    check("R7", "set beats clear", irq_flag, 1);
    set_keys(4'b1111);
    clear_flag();
    check("R7", "later clear works", irq_flag, 0);
  endtask

  task automatic t_stop_rst();
    write_mode(2'b00);
    op_mode = 2'b10;
    rst_en = 1'b1;
    int_en = 1'b0;
    idle(4);
    zero_counts();
    set_keys(4'b1011);
    check("R8", "rst req pulses", rst_cnt, 1);
    check("R8", "wake pulses", wake_cnt, 1);
    check("R8", "flag untouched", irq_flag, 0);
    set_keys(4'b1111);
    write_mode(2'b01);
    zero_counts();
    set_keys(4'b0111);
    check("R8", "rst req with source 01", rst_cnt, 1);
    check("R8", "flag untouched source 01", irq_flag, 0);
    set_keys(4'b1111);
  endtask

  task automatic t_stop_wake();
    rst_en = 1'b0;
    int_en = 1'b0;
    idle(4);
    zero_counts();
    set_keys(4'b1110);
    check("R9", "flag in STOP", irq_flag, 1);
    check("R9", "no wake int disabled", wake_cnt, 0);
    check("R9", "no rst req", rst_cnt, 0);
    set_keys(4'b1111);
    clear_flag();
    int_en = 1'b1;
    zero_counts();
    set_keys(4'b1101);
    check("R9", "flag int enabled", irq_flag, 1);
    check("R9", "wake int enabled", wake_cnt, 1);
    check("R9", "no rst req int enabled", rst_cnt, 0);
    set_keys(4'b1111);
    clear_flag();
    op_mode = 2'b00;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_mask();
    t_prohib();
    t_side();
    t_setwins();
    t_stop_rst();
    t_stop_wake();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule